// File: doc/BRIEF.md
# Reset-Time Configuration Boot Loader

After a hardware reset this block decides, from a strap input captured at reset release, whether to load a configuration image before the processor core may run. When loading is enabled it fetches the image one byte at a time from an external serial ROM through a byte-read handshake with an I2C master. It checks a three-byte signature at the start of the image. It then turns each eight-byte record into a write on a configuration register bus. It finishes by comparing a CRC-32 stored at the end of the image with one computed over everything read before it.

The core reset output stays asserted for the whole load. It is released only when the signature matched and the CRC agreed. Any failure leaves the core held and raises an error flag. When the strap says loading is disabled, the core is released at once, no ROM access is made, and the registers keep their default contents. The bit-level I2C engine sits outside this block.

Top module: `cfg_boot_loader`

## Requirements
- R1: `strap_en` is captured on the first rising clock edge after `rst_n` goes high. Changes to `strap_en` after that edge have no effect until the next reset.
- R2: With the strap captured low, `core_rst_n` goes high on that first edge. `rd_req` never asserts, and `boot_done` and `boot_err` stay low.
- R3: `core_rst_n` is low during reset. With the strap captured high, `core_rst_n` stays low until it rises in the same cycle as `boot_done`.
- R4: The ROM address is two bytes wide. It starts at `ROM_BASE` (0 by default) and advances by one after each byte is transferred, which happens in a cycle with `rd_req` and `rd_ack` both high. While `rd_req` is high without `rd_ack`, both the request and `rd_addr` hold.
- R5: The first three bytes must be 0xAA, 0x55 and 0xC3, in that order. On any mismatch `boot_err` sets after the third byte, and no write or further read follows.
- R6: A record is 4 address bytes followed by 4 data bytes, each most significant byte first. For each record `wr_valid` pulses for exactly one cycle carrying that address and data. No further read is requested until `wr_ready` has been seen high, either in the pulse cycle or in a later cycle.
- R7: A record whose address is 0xFFFFFFFF ends the record list. No write is issued for it, but its eight bytes still count toward the CRC.
- R8: The CRC is CRC-32 with polynomial 0x04C11DB7 and an initial value of all ones. It processes each byte most significant bit first, has no final inversion, and covers every byte from the first signature byte through the end record. It is stored as four bytes, most significant first, right after the end record. A match sets `boot_done` and releases the core. A mismatch sets `boot_err` and keeps the core held.
- R9: `boot_done` and `boot_err` never both assert. Once either one is set it stays set, together with its core-reset state, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| strap_en | input | 1 | Load-enable strap, captured at reset release |
| rd_req | output | 1 | Byte read request to the I2C master |
| rd_addr | output | ROM_AW | Two-byte serial ROM address of the requested byte |
| rd_ack | input | 1 | Byte delivered this cycle |
| rd_data | input | 8 | Byte read from the ROM, valid with `rd_ack` |
| wr_valid | output | 1 | One-cycle configuration write pulse |
| wr_addr | output | REG_AW | Configuration register address |
| wr_data | output | REG_DW | Configuration register data |
| wr_ready | input | 1 | Register bus has accepted the write |
| core_rst_n | output | 1 | Processor core reset, active low |
| boot_done | output | 1 | Image loaded and checked |
| boot_err | output | 1 | Signature or CRC failure |

## Verification
Each result is due a fixed number of edges after the stimulus that causes it:
- `core_rst_n` rises on the first edge after reset release when loading is disabled.
- `wr_valid` appears on the edge that takes in the eighth byte of a record.
- After a write pulse, the next `rd_req` follows on the edge that samples `wr_ready` high.
- `boot_done` or `boot_err` appears on the edge that takes in the third signature byte or the last CRC byte.

The bench drives all inputs and samples all outputs on falling edges, half a cycle away from these updates. Every expected value is therefore read only after the edge that produces it has passed. Final status, read and write counts are compared once a run settles. The status is then watched for ten more cycles to show that nothing else moves.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    localparam int          CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam int          PRE_BYTES = 3;
    localparam int          CRC_BYTES = CRC_W / 8;

    typedef enum logic [3:0] {
        ST_SAMPLE,
        ST_OFF,
        ST_PRE,
        ST_REC,
        ST_WR,
        ST_WAIT,
        ST_CRC,
        ST_DONE,
        ST_FAIL
    } boot_st_e;

endpackage

// File: rtl/cfgb_crc_step.sv
module cfgb_crc_step #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
    input  logic [W-1:0] crc_i,
    input  logic [7:0]   byte_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] stage [0:8];

    assign stage[0] = crc_i;

    for (genvar g = 0; g < 8; g++) begin : g_bit
        logic fb;
        assign fb           = stage[g][W-1] ^ byte_i[7-g];
        assign stage[g + 1] = {stage[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = stage[8];
endmodule

// File: rtl/cfgb_byte_collect.sv
module cfgb_byte_collect #(
    parameter  int NBYTES = 8,
    localparam int SH_W   = 8 * NBYTES,
    localparam int CW     = $clog2(NBYTES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            clr,
    input  logic [7:0]      byte_i,
    output logic [SH_W-1:0] sh_o,
    output logic [CW-1:0]   cnt_o
);
    typedef struct packed {
        logic [SH_W-1:0] sh;
        logic [CW-1:0]   cnt;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (push) begin
            col_d.sh = {col_q.sh[SH_W-9:0], byte_i};
        end
        if (clr) begin
            col_d.cnt = '0;
        end else if (push) begin
            col_d.cnt = col_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign sh_o  = col_q.sh;
    assign cnt_o = col_q.cnt;
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
    import cfg_boot_pkg::*;
#(
    parameter int                ROM_AW   = 16,
    parameter int                REG_AW   = 32,
    parameter int                REG_DW   = 32,
    parameter logic [23:0]       PREAMBLE = 24'hAA55C3,
    parameter logic [ROM_AW-1:0] ROM_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_en,
    output logic              rd_req,
    output logic [ROM_AW-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic              wr_valid,
    output logic [REG_AW-1:0] wr_addr,
    output logic [REG_DW-1:0] wr_data,
    input  logic              wr_ready,
    output logic              core_rst_n,
    output logic              boot_done,
    output logic              boot_err
);
    localparam int REC_BYTES = (REG_AW + REG_DW) / 8;
    localparam int SH_W      = 8 * REC_BYTES;
    localparam int CW        = $clog2(REC_BYTES + 1);
    localparam logic [REG_AW-1:0] END_MARK = '1;

    typedef struct packed {
        boot_st_e          st;
        logic [ROM_AW-1:0] addr;
        logic [CRC_W-1:0]  crc;
    } regs_t;

    regs_t r_d, r_q;

    logic [SH_W-1:0]  sh_q;
    logic [SH_W-1:0]  sh_new;
    logic [CW-1:0]    cnt_q;
    logic             push;
    logic             clr;
    logic [CRC_W-1:0] crc_next;

    assign rd_req = (r_q.st == ST_PRE) || (r_q.st == ST_REC) || (r_q.st == ST_CRC);
    assign push   = rd_req && rd_ack;
    assign sh_new = {sh_q[SH_W-9:0], rd_data};

    cfgb_byte_collect #(.NBYTES(REC_BYTES)) u_collect (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .clr    (clr),
        .byte_i (rd_data),
        .sh_o   (sh_q),
        .cnt_o  (cnt_q)
    );

    cfgb_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (r_q.crc),
        .byte_i (rd_data),
        .crc_o  (crc_next)
    );

    always_comb begin
        r_d      = r_q;
        clr      = 1'b0;
        wr_valid = 1'b0;
        if (push) begin
            r_d.addr = r_q.addr + 1'b1;
        end
        unique case (r_q.st)
            ST_SAMPLE: r_d.st = strap_en ? ST_PRE : ST_OFF;
            ST_PRE: begin
                if (push) begin
                    r_d.crc = crc_next;
                    if (cnt_q == CW'(PRE_BYTES - 1)) begin
                        clr    = 1'b1;
                        r_d.st = (sh_new[23:0] == PREAMBLE) ? ST_REC : ST_FAIL;
                    end
                end
            end
            ST_REC: begin
                if (push) begin
                    r_d.crc = crc_next;
                    if (cnt_q == CW'(REC_BYTES - 1)) begin
                        clr    = 1'b1;
                        r_d.st = (sh_new[SH_W-1 -: REG_AW] == END_MARK) ? ST_CRC : ST_WR;
                    end
                end
            end
            ST_WR: begin
                wr_valid = 1'b1;
                r_d.st   = wr_ready ? ST_REC : ST_WAIT;
            end
            ST_WAIT: begin
                if (wr_ready) begin
                    r_d.st = ST_REC;
                end
            end
            ST_CRC: begin
                if (push && (cnt_q == CW'(CRC_BYTES - 1))) begin
                    clr    = 1'b1;
                    r_d.st = (sh_new[CRC_W-1:0] == r_q.crc) ? ST_DONE : ST_FAIL;
                end
            end
            default: r_d.st = r_q.st;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_SAMPLE;
            r_q.addr <= ROM_BASE;
            r_q.crc  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr    = r_q.addr;
    assign wr_addr    = sh_q[SH_W-1 -: REG_AW];
    assign wr_data    = sh_q[REG_DW-1:0];
    assign boot_done  = (r_q.st == ST_DONE);
    assign boot_err   = (r_q.st == ST_FAIL);
    assign core_rst_n = (r_q.st == ST_DONE) || (r_q.st == ST_OFF);

    // R4: request and address hold until the byte arrives
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R4: one address step per transferred byte
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> (rd_addr == $past(rd_addr) + 1'b1));

    // R6: write pulse lasts exactly one cycle
    p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R6: no read while the write is still unaccepted
    p_no_read_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> !rd_req);

    // R3: core stays held while the ROM is being read
    p_core_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !core_rst_n);

    // R9: error is sticky and keeps the core held
    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> (boot_err && !core_rst_n));

    // R9: done is sticky and keeps the core released
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> (boot_done && core_rst_n && !rd_req));
endmodule

// File: tb/cfg_boot_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb_top;

    logic        clk      = 1'b0;
    logic        rst_n    = 1'b0;
    logic        strap_en = 1'b0;
    logic        rd_ack   = 1'b0;
    logic [7:0]  rd_data  = 8'h00;
    logic        wr_ready = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        core_rst_n;
    logic        boot_done;
    logic        boot_err;

    always #10 clk = ~clk;

    cfg_boot_loader dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_en   (strap_en),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .core_rst_n (core_rst_n),
        .boot_done  (boot_done),
        .boot_err   (boot_err)
    );

    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    logic [7:0]  rom [0:255];
    int          rom_len;
    logic [31:0] exp_a [0:15];
    logic [31:0] exp_d [0:15];
    int          n_exp;
    int          rd_cnt, wr_cnt, lat, wdly, addr_bad, ready_mode;
    bit          waiting, strap_run, hold_viol, rd_in_wait;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = (r << 1) ^ 32'h04C1_1DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic put32(inout int p, input logic [31:0] v);
        for (int k = 3; k >= 0; k--) begin
            rom[p] = v[8*k +: 8];
            p++;
        end
    endtask

    task automatic build_image(input int nrec, input int pre_bad, input bit crc_bad);
        int          p = 0;
        logic [31:0] c = 32'hFFFF_FFFF;
        rom[0] = 8'hAA; rom[1] = 8'h55; rom[2] = 8'hC3;
        if (pre_bad >= 0) rom[pre_bad] = rom[pre_bad] ^ 8'h10;
        p = 3;
        n_exp = nrec;
        for (int r = 0; r < nrec; r++) begin
            exp_a[r] = $urandom() & 32'h7FFF_FFFF;
            exp_d[r] = $urandom();
            put32(p, exp_a[r]);
            put32(p, exp_d[r]);
        end
        put32(p, 32'hFFFF_FFFF);
        put32(p, $urandom());
        for (int i = 0; i < p; i++) c = crc_byte(c, rom[i]);
        if (crc_bad) c = c ^ (32'h1 << ($urandom() % 32));
        put32(p, c);
        rom_len = p;
    endtask

    // ROM model and register sink, all on falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (lat == 0) begin
                    if (rd_addr != rd_cnt[15:0]) addr_bad++;
                    rd_data = rom[rd_addr[7:0]];
                    rd_ack  = 1'b1;
                    rd_cnt++;
                    lat = $urandom() % 3;
                end else begin
                    lat--;
                end
            end
            if (wr_ready) wr_ready = 1'b0;
            if (wr_valid) begin
                if (wr_cnt >= n_exp) begin
                    chk(1'b0, "R7", "write beyond record list", wr_cnt, n_exp);
                end else begin
                    chk(wr_addr == exp_a[wr_cnt], "R6", "write address", wr_addr, exp_a[wr_cnt]);
                    chk(wr_data == exp_d[wr_cnt], "R6", "write data", wr_data, exp_d[wr_cnt]);
                end
                wr_cnt++;
                case (ready_mode)
                    1:       wdly = 0;
                    2:       wdly = 3 + ($urandom() % 3);
                    default: wdly = $urandom() % 3;
                endcase
                if (wdly == 0) wr_ready = 1'b1;
                else           waiting  = 1'b1;
            end else if (waiting) begin
                if (rd_req) rd_in_wait = 1'b1;
                if (wdly <= 1) begin
                    wr_ready = 1'b1;
                    waiting  = 1'b0;
                end else begin
                    wdly--;
                end
            end
            if (strap_run && (core_rst_n != boot_done)) hold_viol = 1'b1;
        end
    end

    task automatic enter_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; lat = 0; wdly = 0; addr_bad = 0;
        waiting = 0; hold_viol = 0; rd_in_wait = 0; strap_run = 0;
        rd_ack = 1'b0; wr_ready = 1'b0;
        strap_en = strap;
        repeat (2) @(negedge clk);
        chk(!core_rst_n && !rd_req && !wr_valid && !boot_done && !boot_err,
            "R3", "reset state", {core_rst_n, rd_req, boot_done, boot_err}, 0);
    endtask

    task automatic run_off();
        n_exp = 0;
        enter_reset(1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_rst_n && !rd_req && !boot_done && !boot_err, "R2", "strap low release",
            {core_rst_n, rd_req, boot_done, boot_err}, 4'b1000);
        strap_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(rd_cnt == 0 && core_rst_n && !boot_done, "R1", "late strap ignored",
            rd_cnt, 0);
    endtask

    task automatic run_boot(input int nrec, input int pre_bad, input bit crc_bad,
                            input int rmode, input bit drop);
        int t = 0;
        int rd_snap;
        build_image(nrec, pre_bad, crc_bad);
        ready_mode = rmode;
        enter_reset(1'b1);
        strap_run = 1'b1;
        rst_n     = 1'b1;
        if (drop) begin
            @(negedge clk);
            strap_en = 1'b0;
        end
        while (!(boot_done || boot_err) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 5000, "R3", "load finished", t, 5000);
        if (pre_bad >= 0) begin
            chk(boot_err && !boot_done && !core_rst_n, "R5", "signature mismatch status",
                {boot_done, boot_err, core_rst_n}, 3'b010);
            chk(wr_cnt == 0, "R5", "writes after bad signature", wr_cnt, 0);
            chk(rd_cnt == 3, "R5", "reads after bad signature", rd_cnt, 3);
        end else begin
            if (crc_bad)
                chk(boot_err && !boot_done && !core_rst_n, "R8", "bad crc status",
                    {boot_done, boot_err, core_rst_n}, 3'b010);
            else
                chk(boot_done && !boot_err && core_rst_n, "R8", "good crc status",
                    {boot_done, boot_err, core_rst_n}, 3'b101);
            chk(wr_cnt == nrec, "R7", "write count", wr_cnt, nrec);
            chk(rd_cnt == rom_len, "R4", "byte count", rd_cnt, rom_len);
        end
        rd_snap = rd_cnt;
        repeat (10) @(negedge clk);
        chk(rd_cnt == rd_snap && (boot_done || boot_err) && !rd_req, "R9", "status sticky",
            rd_cnt, rd_snap);
        chk(!hold_viol, "R3", "core release tied to done", hold_viol, 0);
        chk(!rd_in_wait, "R6", "read during write wait", rd_in_wait, 0);
        chk(addr_bad == 0, "R4", "rom address sequence", addr_bad, 0);
        strap_run = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        run_off();                        // R1, R2
        run_boot(3, -1, 1'b0, 1, 1'b0);   // R6, R8 with immediate ready
        run_boot(0, -1, 1'b0, 0, 1'b0);   // R7 empty record list
        run_boot(2, 0, 1'b0, 0, 1'b0);    // R5 first signature byte wrong
        run_boot(2, 2, 1'b0, 0, 1'b0);    // R5 last signature byte wrong
        run_boot(3, -1, 1'b1, 0, 1'b0);   // R8 corrupted crc
        run_boot(4, -1, 1'b0, 2, 1'b1);   // R1 strap dropped, R6 slow ready
        for (int i = 0; i < 6; i++) begin
            run_boot($urandom() % 8, -1, ($urandom() % 4) == 0, $urandom() % 3, 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule